// File: doc/BRIEF.md
# Transport-Triggered Move Core

This block is a small processor datapath whose only instruction is a 16-bit move from one transport register to another. It has no opcode. Arithmetic happens as a side effect of a move: each functional unit exposes an A operand port, a B operand port and a result port in a shared 128-entry transport address space. Writing the B port with the execute bit set fires that unit. Its result lands in the unit's result register one clock later.

The same address space holds 64 general registers. It also holds a branch adder unit: firing it redirects the fetch counter to the sum of its operands. The core presents a fetch address and takes one instruction per cycle on its instruction port when the valid input is high. It reports every executed move on a registered observation bus. Bit 15 of the instruction marks a move as pairable with the next move. The core reports this mark but always issues one move per cycle. A move with the execute bit set that does not land on a B port still performs its write, and it raises a sticky illegal-trigger flag.

Top module: `ttm_core`

## Requirements
- R1: After reset, or while rst_ni is low, the fetch address is 0, illegal_o and mv_valid_o are 0, and every general, operand and result register reads as 0.
- R2: A move is executed in each cycle that instr_valid_i is high. The value read from the source address is written to the destination address. One cycle later mv_valid_o is 1, mv_dst_o holds the destination and mv_data_o holds the moved value. In a cycle with instr_valid_i low, mv_valid_o is 0 on the next cycle.
- R3: Instruction fields are: source address in bits 6..0, destination address in bits 13..7, execute in bit 14, pair in bit 15. One cycle after a move, mv_pair_o equals that move's bit 15. The pair bit has no other effect.
- R4: Address map. 0x00-0x3F are general registers. Unit u (0 add, 1 subtract, 2 AND, 3 equality, 4 branch adder) owns 0x40+4u (A), 0x41+4u (B) and 0x42+4u (result, read-only). Address 0x53 reads the fetch address of the move being executed. All other addresses read 0. Writes to result addresses and to unassigned addresses are discarded.
- R5: A move into a B port with bit 14 set fires the unit on the operands held after that move. A move in the next cycle still reads the old result. A move two cycles after the trigger reads the new one.
- R6: A move into a B port with bit 14 clear latches the operand, and the unit's result register stays unchanged.
- R7: Results are computed modulo 2^16. Add gives A+B, subtract gives A-B, AND gives the bitwise AND, and equality gives 1 when A equals B and 0 otherwise.
- R8: When the branch adder fires, the move right after the trigger (one delay slot) is still taken from the sequential address. The fetch address then becomes A+B of the branch unit.
- R9: A move with bit 14 set whose destination is not a B port performs its write as if bit 14 were clear. It also sets illegal_o, which then stays 1 until reset.
- R10: Without a redirect, the fetch address increments by 1 after each executed move and holds while instr_valid_i is low.
- R11: A fired unit completes on the next clock even when no move is executed in that cycle, and a branch redirect still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Move instruction at the current fetch address |
| instr_valid_i | input | 1 | instr_i holds a move to execute this cycle |
| fetch_addr_o | output | 16 | Fetch counter |
| mv_valid_o | output | 1 | A move was executed in the previous cycle |
| mv_dst_o | output | 7 | Destination of that move |
| mv_data_o | output | 16 | Value transported by that move |
| mv_pair_o | output | 1 | Pair bit of that move |
| illegal_o | output | 1 | Sticky illegal-trigger flag |

## Verification
The observation bus reports each move one clock after the move is presented, so every expected entry is stamped with that due cycle. A monitor compares the entry on the falling edge of that cycle. A unit result becomes visible to a move presented two cycles after the trigger, and the fetch address changes after one delay slot. A model advanced once per presented move tracks both delays, so a value read too early or a redirect taken too soon shows up in the compared data or fetch address. The fetch address and the illegal flag are compared on every falling edge against the model state after the preceding clock.

// File: rtl/ttm_pkg.sv
package ttm_pkg;
  localparam int INSTR_W = 16;
  localparam int TADDR_W = 7;
  localparam int N_UNITS = 5;
  localparam int BR_UNIT = N_UNITS - 1;
  localparam int UIDX_W  = $clog2(N_UNITS);
  localparam int N_SLOT  = 1 << UIDX_W;
  localparam logic [TADDR_W-1:0] UNIT_BASE = 7'h40;

  typedef struct packed {
    logic               pair;
    logic               exec;
    logic [TADDR_W-1:0] dst;
    logic [TADDR_W-1:0] src;
  } move_t;

  typedef enum logic [1:0] {
    PORT_A   = 2'd0,
    PORT_B   = 2'd1,
    PORT_RES = 2'd2,
    PORT_AUX = 2'd3
  } port_e;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_EQ  = 2'd3
  } unit_op_e;

  function automatic unit_op_e op_of(int idx);
    case (idx)
      1:       return OP_SUB;
      2:       return OP_AND;
      3:       return OP_EQ;
      default: return OP_ADD;
    endcase
  endfunction

  function automatic logic [TADDR_W-1:0] port_addr(int unit, port_e p);
    return UNIT_BASE + TADDR_W'(4 * unit) + TADDR_W'(p);
  endfunction
endpackage

// File: rtl/ttm_addr_dec.sv
module ttm_addr_dec
  import ttm_pkg::*;
#(
  parameter int N_GPR = 64
) (
  input  logic [TADDR_W-1:0] addr_i,
  output logic               is_gpr_o,
  output logic               is_unit_o,
  output logic [UIDX_W-1:0]  idx_o,
  output port_e              port_o
);
  logic [TADDR_W-1:0] off;

  assign off       = addr_i - UNIT_BASE;
  assign is_gpr_o  = (int'(addr_i) < N_GPR);
  assign is_unit_o = (addr_i >= UNIT_BASE) && (int'(off[TADDR_W-1:2]) < N_UNITS);
  assign idx_o     = off[2 +: UIDX_W];
  assign port_o    = port_e'(off[1:0]);
endmodule

// File: rtl/ttm_gpr_file.sv
module ttm_gpr_file #(
  parameter int N = 64,
  parameter int W = 16,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ttm_unit.sv
module ttm_unit
  import ttm_pkg::*;
#(
  parameter int       W  = 16,
  parameter unit_op_e OP = OP_ADD
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_a_i,
  input  logic         wr_b_i,
  input  logic         trig_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] res_o,
  output logic         fire_o,
  output logic [W-1:0] res_next_o
);
  logic [W-1:0] a_q, b_q, res_q, nx;
  logic         pend_q;

  always_comb begin
    case (OP)
      OP_SUB:  nx = a_q - b_q;
      OP_AND:  nx = a_q & b_q;
      OP_EQ:   nx = {{(W-1){1'b0}}, (a_q == b_q)};
      default: nx = a_q + b_q;
    endcase
  end

  // operands captured by the trigger move are consumed on the following edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      res_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_a_i) a_q <= wdata_i;
      if (wr_b_i) b_q <= wdata_i;
      if (pend_q) res_q <= nx;
      pend_q <= trig_i & wr_b_i;
    end
  end

  assign a_o        = a_q;
  assign b_o        = b_q;
  assign res_o      = res_q;
  assign fire_o     = pend_q;
  assign res_next_o = nx;
endmodule

// File: rtl/ttm_fetch.sv
module ttm_fetch #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         redirect_i,
  input  logic [W-1:0] target_i,
  output logic [W-1:0] pc_o
);
  logic [W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pc_q <= '0;
    else if (redirect_i) pc_q <= target_i;
    else if (adv_i)      pc_q <= pc_q + 1'b1;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/ttm_core.sv
module ttm_core
  import ttm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N_GPR  = 64,
  localparam int GAW   = $clog2(N_GPR)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [INSTR_W-1:0]    instr_i,
  input  logic                  instr_valid_i,
  output logic [DATA_W-1:0]     fetch_addr_o,
  output logic                  mv_valid_o,
  output logic [TADDR_W-1:0]    mv_dst_o,
  output logic [DATA_W-1:0]     mv_data_o,
  output logic                  mv_pair_o,
  output logic                  illegal_o
);
  move_t              mv;
  logic               go;
  logic               s_is_gpr, s_is_unit, d_is_gpr, d_is_unit;
  logic [UIDX_W-1:0]  s_idx, d_idx;
  port_e              s_port, d_port;
  logic [DATA_W-1:0]  gpr_rdata, rd_data, fetch_addr;
  logic [DATA_W-1:0]  u_a [N_SLOT];
  logic [DATA_W-1:0]  u_b [N_SLOT];
  logic [DATA_W-1:0]  u_res [N_SLOT];
  logic [DATA_W-1:0]  u_next [N_SLOT];
  logic               u_fire [N_SLOT];
  logic               br_fire;
  logic [DATA_W-1:0]  br_target;
  logic               to_b_port, bad_trig;
  logic               mv_valid_q, mv_pair_q, illegal_q;
  logic [TADDR_W-1:0] mv_dst_q;
  logic [DATA_W-1:0]  mv_data_q;

  assign mv = move_t'(instr_i);
  assign go = instr_valid_i;

  ttm_addr_dec #(.N_GPR(N_GPR)) u_src_dec (
    .addr_i   (mv.src),
    .is_gpr_o (s_is_gpr),
    .is_unit_o(s_is_unit),
    .idx_o    (s_idx),
    .port_o   (s_port)
  );

  ttm_addr_dec #(.N_GPR(N_GPR)) u_dst_dec (
    .addr_i   (mv.dst),
    .is_gpr_o (d_is_gpr),
    .is_unit_o(d_is_unit),
    .idx_o    (d_idx),
    .port_o   (d_port)
  );

  ttm_gpr_file #(.N(N_GPR), .W(DATA_W)) u_gpr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (go & d_is_gpr),
    .waddr_i(mv.dst[GAW-1:0]),
    .wdata_i(rd_data),
    .raddr_i(mv.src[GAW-1:0]),
    .rdata_o(gpr_rdata)
  );

  for (genvar u = 0; u < N_SLOT; u++) begin : g_slot
    if (u < N_UNITS) begin : g_unit
      logic sel;
      assign sel = go & d_is_unit & (d_idx == UIDX_W'(u));
      ttm_unit #(.W(DATA_W), .OP(op_of(u))) u_unit (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_a_i    (sel & (d_port == PORT_A)),
        .wr_b_i    (sel & (d_port == PORT_B)),
        .trig_i    (mv.exec),
        .wdata_i   (rd_data),
        .a_o       (u_a[u]),
        .b_o       (u_b[u]),
        .res_o     (u_res[u]),
        .fire_o    (u_fire[u]),
        .res_next_o(u_next[u])
      );
    end else begin : g_pad
      assign u_a[u]    = '0;
      assign u_b[u]    = '0;
      assign u_res[u]  = '0;
      assign u_next[u] = '0;
      assign u_fire[u] = 1'b0;
    end
  end

  // transport read mux
  always_comb begin
    rd_data = '0;
    if (s_is_gpr) begin
      rd_data = gpr_rdata;
    end else if (s_is_unit) begin
      case (s_port)
        PORT_A:   rd_data = u_a[s_idx];
        PORT_B:   rd_data = u_b[s_idx];
        PORT_RES: rd_data = u_res[s_idx];
        default:  if (int'(s_idx) == BR_UNIT) rd_data = fetch_addr;
      endcase
    end
  end

  assign br_fire   = u_fire[BR_UNIT];
  assign br_target = u_next[BR_UNIT];

  ttm_fetch #(.W(DATA_W)) u_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (go),
    .redirect_i(br_fire),
    .target_i  (br_target),
    .pc_o      (fetch_addr)
  );

  assign to_b_port = d_is_unit & (d_port == PORT_B);
  assign bad_trig  = go & mv.exec & ~to_b_port;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mv_valid_q <= 1'b0;
      mv_dst_q   <= '0;
      mv_data_q  <= '0;
      mv_pair_q  <= 1'b0;
      illegal_q  <= 1'b0;
    end else begin
      mv_valid_q <= go;
      mv_dst_q   <= mv.dst;
      mv_data_q  <= rd_data;
      mv_pair_q  <= go & mv.pair;
      if (bad_trig) illegal_q <= 1'b1;
    end
  end

  assign fetch_addr_o = fetch_addr;
  assign mv_valid_o   = mv_valid_q;
  assign mv_dst_o     = mv_dst_q;
  assign mv_data_o    = mv_data_q;
  assign mv_pair_o    = mv_pair_q;
  assign illegal_o    = illegal_q;
endmodule

// File: rtl/ttm_core_chk.sv
module ttm_core_chk
  import ttm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [INSTR_W-1:0]   instr_i,
  input logic                 instr_valid_i,
  input logic [DATA_W-1:0]    fetch_addr_o,
  input logic                 mv_valid_o,
  input logic [TADDR_W-1:0]   mv_dst_o,
  input logic                 mv_pair_o,
  input logic                 illegal_o,
  input logic                 br_fire_i,
  input logic [DATA_W-1:0]    br_target_i
);
  localparam logic [TADDR_W-1:0] BR_B = port_addr(BR_UNIT, PORT_B);

  p_rst_state_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (fetch_addr_o == '0) && !illegal_o && !mv_valid_o);

  p_mv_echo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i |=> mv_valid_o && (mv_dst_o == $past(instr_i[13:7])));

  p_no_mv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> !mv_valid_o);

  p_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i |=> (mv_pair_o == $past(instr_i[15])));

  p_trigger_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && instr_i[14] && (instr_i[13:7] == BR_B) |=> br_fire_i);

  p_redirect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_fire_i |=> (fetch_addr_o == $past(br_target_i)));

  p_illegal_gpr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && instr_i[14] && !instr_i[13] |=> illegal_o);

  p_illegal_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o);

  p_fetch_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && !br_fire_i |=> (fetch_addr_o == DATA_W'($past(fetch_addr_o) + 1'b1)));

  p_fetch_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i && !br_fire_i |=> $stable(fetch_addr_o));
endmodule

bind ttm_core ttm_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .instr_i      (instr_i),
  .instr_valid_i(instr_valid_i),
  .fetch_addr_o (fetch_addr_o),
  .mv_valid_o   (mv_valid_o),
  .mv_dst_o     (mv_dst_o),
  .mv_pair_o    (mv_pair_o),
  .illegal_o    (illegal_o),
  .br_fire_i    (br_fire),
  .br_target_i  (br_target)
);

// File: tb/tb_ttm_core.sv
`timescale 1ns/1ps
module tb_ttm_core;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [15:0] instr_i;
  logic        instr_valid_i;
  logic [15:0] fetch_addr_o;
  logic        mv_valid_o;
  logic [6:0]  mv_dst_o;
  logic [15:0] mv_data_o;
  logic        mv_pair_o;
  logic        illegal_o;

  ttm_core dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .instr_i      (instr_i),
    .instr_valid_i(instr_valid_i),
    .fetch_addr_o (fetch_addr_o),
    .mv_valid_o   (mv_valid_o),
    .mv_dst_o     (mv_dst_o),
    .mv_data_o    (mv_data_o),
    .mv_pair_o    (mv_pair_o),
    .illegal_o    (illegal_o)
  );

  always #2.5 clk = ~clk;

  int    n_checks = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";
  string pc_tag = "R1";

  typedef struct {
    int          due;
    logic        v;
    logic [6:0]  dst;
    logic [15:0] data;
    logic        par;
    string       tag;
  } exp_t;
  exp_t q[$];

  // reference state
  logic [15:0] m_gpr [64];
  logic [15:0] m_a [5];
  logic [15:0] m_b [5];
  logic [15:0] m_res [5];
  logic        m_pend [5];
  logic [15:0] m_pc;
  logic        m_ill;

  always @(posedge clk) cyc++;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mv(bit par, bit ex, logic [6:0] dst, logic [6:0] src);
    return {par, ex, dst, src};
  endfunction

  function automatic logic [15:0] m_op(int u, logic [15:0] a, logic [15:0] b);
    case (u)
      1:       return a - b;
      2:       return a & b;
      3:       return (a == b) ? 16'd1 : 16'd0;
      default: return a + b;
    endcase
  endfunction

  function automatic bit is_unit(logic [6:0] ad);
    return (ad >= 7'h40) && ((int'(ad) - 64) / 4 < 5);
  endfunction

  function automatic logic [15:0] m_read(logic [6:0] s);
    int u, p;
    if (s < 7'h40) return m_gpr[s[5:0]];
    if (!is_unit(s)) return 16'h0;
    u = (int'(s) - 64) / 4;
    p = (int'(s) - 64) % 4;
    case (p)
      0:       return m_a[u];
      1:       return m_b[u];
      2:       return m_res[u];
      default: return (u == 4) ? m_pc : 16'h0;
    endcase
  endfunction

  task automatic m_clear();
    for (int i = 0; i < 64; i++) m_gpr[i] = '0;
    for (int i = 0; i < 5; i++) begin
      m_a[i] = '0; m_b[i] = '0; m_res[i] = '0; m_pend[i] = 1'b0;
    end
    m_pc = '0;
    m_ill = 1'b0;
  endtask

  // driver: one presented move per call
  task automatic step(bit v, logic [15:0] ins);
    exp_t e;
    logic [6:0] d;
    int u, p;
    logic br;
    logic [15:0] tgt;
    @(negedge clk);
    chk(fetch_addr_o == m_pc, pc_tag, "fetch_addr", fetch_addr_o, m_pc);
    chk(illegal_o == m_ill, "R9", "illegal", illegal_o, m_ill);
    instr_valid_i = v;
    instr_i = ins;
    d = ins[13:7];
    e.due = cyc + 1;
    e.v = v;
    e.dst = d;
    e.data = m_read(ins[6:0]);
    e.par = ins[15];
    e.tag = cur_tag;
    q.push_back(e);
    br = m_pend[4];
    tgt = m_a[4] + m_b[4];
    for (int k = 0; k < 5; k++) begin
      if (m_pend[k]) begin
        m_res[k] = m_op(k, m_a[k], m_b[k]);
        m_pend[k] = 1'b0;
      end
    end
    if (v) begin
      if (d < 7'h40) m_gpr[d[5:0]] = e.data;
      else if (is_unit(d)) begin
        u = (int'(d) - 64) / 4;
        p = (int'(d) - 64) % 4;
        if (p == 0) m_a[u] = e.data;
        if (p == 1) begin
          m_b[u] = e.data;
          if (ins[14]) m_pend[u] = 1'b1;
        end
      end
      if (ins[14] && !(is_unit(d) && ((int'(d) - 64) % 4 == 1))) m_ill = 1'b1;
    end
    pc_tag = br ? "R8" : (v ? "R10" : "R11");
    m_pc = br ? tgt : (v ? m_pc + 16'd1 : m_pc);
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) step(1'b1, mv(0, 0, 7'h00, 7'h00));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0);
  endtask

  // monitor: compares the observation bus when each entry falls due
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(mv_valid_o == e.v, e.tag, "mv_valid", mv_valid_o, e.v);
      if (e.v) begin
        chk(mv_dst_o == e.dst, e.tag, "mv_dst", mv_dst_o, e.dst);
        chk(mv_data_o == e.data, e.tag, "mv_data", mv_data_o, e.data);
        chk(mv_pair_o == e.par, e.tag, "mv_pair", mv_pair_o, e.par);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    instr_valid_i = 1'b0;
    instr_i = '0;
    q.delete();
    m_clear();
    pc_tag = "R1";
    repeat (3) @(negedge clk);
    chk(fetch_addr_o == 16'h0, "R1", "fetch_addr in reset", fetch_addr_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(fetch_addr_o == 16'h0, "R1", "fetch_addr", fetch_addr_o, 0);
    chk(illegal_o == 1'b0, "R1", "illegal", illegal_o, 0);
    chk(mv_valid_o == 1'b0, "R1", "mv_valid", mv_valid_o, 0);
  endtask

  initial begin
    rst_ni = 1'b0;
    instr_valid_i = 1'b0;
    instr_i = '0;
    m_clear();
    do_reset();

    cur_tag = "R1";
    step(1, mv(0, 0, 7'h06, 7'h05));
    step(1, mv(0, 0, 7'h07, 7'h42));
    step(1, mv(0, 0, 7'h08, 7'h51));
    step(1, mv(0, 0, 7'h09, 7'h4E));

    cur_tag = "R2";
    step(1, mv(0, 0, 7'h01, 7'h53));
    step(1, mv(0, 0, 7'h02, 7'h01));
    step(1, mv(0, 0, 7'h3F, 7'h02));
    step(1, mv(0, 0, 7'h03, 7'h3F));
    step(1, mv(0, 0, 7'h01, 7'h53));

    cur_tag = "R3";
    step(1, mv(1, 0, 7'h04, 7'h53));
    step(1, mv(1, 0, 7'h05, 7'h04));
    step(1, mv(0, 0, 7'h06, 7'h05));

    cur_tag = "R5";
    step(1, mv(0, 0, 7'h40, 7'h01));
    step(1, mv(0, 1, 7'h41, 7'h53));
    step(1, mv(0, 0, 7'h09, 7'h42));
    step(1, mv(0, 0, 7'h0A, 7'h42));
    step(1, mv(0, 0, 7'h40, 7'h0A));
    step(1, mv(0, 1, 7'h41, 7'h0A));
    step(1, mv(0, 0, 7'h40, 7'h53));
    step(1, mv(0, 0, 7'h0B, 7'h42));

    cur_tag = "R7";
    step(1, mv(0, 0, 7'h44, 7'h53));
    step(1, mv(0, 1, 7'h45, 7'h01));
    nop(1);
    step(1, mv(0, 0, 7'h0B, 7'h46));
    step(1, mv(0, 0, 7'h44, 7'h01));
    step(1, mv(0, 1, 7'h45, 7'h53));
    nop(1);
    step(1, mv(0, 0, 7'h0C, 7'h46));
    step(1, mv(0, 0, 7'h48, 7'h53));
    step(1, mv(0, 1, 7'h49, 7'h0C));
    nop(1);
    step(1, mv(0, 0, 7'h0D, 7'h4A));
    step(1, mv(0, 0, 7'h4C, 7'h01));
    step(1, mv(0, 1, 7'h4D, 7'h01));
    nop(1);
    step(1, mv(0, 0, 7'h0E, 7'h4E));
    step(1, mv(0, 0, 7'h4C, 7'h53));
    step(1, mv(0, 1, 7'h4D, 7'h01));
    nop(1);
    step(1, mv(0, 0, 7'h0F, 7'h4E));

    cur_tag = "R6";
    step(1, mv(0, 0, 7'h41, 7'h53));
    nop(2);
    step(1, mv(0, 0, 7'h10, 7'h42));
    step(1, mv(0, 0, 7'h11, 7'h41));

    cur_tag = "R4";
    step(1, mv(0, 0, 7'h42, 7'h53));
    step(1, mv(0, 0, 7'h12, 7'h42));
    step(1, mv(0, 0, 7'h60, 7'h53));
    step(1, mv(0, 0, 7'h13, 7'h60));
    step(1, mv(0, 0, 7'h14, 7'h47));
    step(1, mv(0, 0, 7'h15, 7'h53));
    step(1, mv(0, 0, 7'h16, 7'h7F));

    cur_tag = "R11";
    step(1, mv(0, 0, 7'h40, 7'h53));
    step(1, mv(0, 1, 7'h41, 7'h01));
    idle(2);
    step(1, mv(0, 0, 7'h17, 7'h42));

    cur_tag = "R10";
    idle(3);
    nop(2);
    idle(1);
    step(1, mv(0, 0, 7'h18, 7'h53));

    cur_tag = "R8";
    step(1, mv(0, 0, 7'h50, 7'h53));
    step(1, mv(0, 1, 7'h51, 7'h01));
    step(1, mv(0, 0, 7'h19, 7'h53));
    step(1, mv(0, 0, 7'h1A, 7'h53));
    step(1, mv(0, 0, 7'h1B, 7'h52));
    step(1, mv(0, 0, 7'h50, 7'h3F));
    step(1, mv(0, 1, 7'h51, 7'h01));
    idle(1);
    step(1, mv(0, 0, 7'h1C, 7'h53));

    cur_tag = "R9";
    step(1, mv(0, 1, 7'h40, 7'h53));
    step(1, mv(0, 0, 7'h1D, 7'h40));
    nop(2);
    do_reset();
    cur_tag = "R1";
    step(1, mv(0, 0, 7'h1E, 7'h1D));
    cur_tag = "R9";
    step(1, mv(0, 1, 7'h20, 7'h53));
    step(1, mv(0, 0, 7'h21, 7'h20));
    step(1, mv(0, 1, 7'h42, 7'h53));
    step(1, mv(0, 0, 7'h22, 7'h42));
    idle(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule